// File: doc/BRIEF.md
# Stereo-Pairable Serial Audio Output Port

This block turns parallel 16-bit two's complement audio samples into a serial stream on one data pin. Framing comes from outside: an external bit clock sets the bit rate, and an external left/right clock marks the two half-frames. Both clocks are sampled by the block's own system clock. A strap input chooses which half-frame this port owns. Because of that strap, two single-channel converters can sit on one shared stereo data line. Each one drives the line only during its own half and leaves it released for the other half.

A second strap picks the framing:
- Left-justified: the most significant bit comes with the first bit-clock falling edge of the half.
- I2S-style: the word is delayed by one bit.

Samples arrive on a valid/ready stream into a one-entry holding register. `s_ready` is high exactly when the register is empty. A sample is taken on any rising system clock edge where `s_valid` and `s_ready` are both high. While the register is full, `s_ready` stays low and the producer must hold its sample until `s_ready` returns.

The register empties into the shift logic at the start of each owned half-frame. If it is empty at that moment, the half carries all zeros. An active-high clear returns the whole block to its idle state, and one clear pulse is needed after power-up.

Top module: `serial_sample_tx`

## Requirements
- R1: Each owned half-frame carries the 16-bit word most significant bit first. A new bit appears on `sdata` after each falling edge of `bclk`, and it holds until the next falling edge.
- R2: With `chan_right`=1 the port owns the half where `lrclk`=1; with `chan_right`=0 it owns the half where `lrclk`=0. `sdata_oe` is 1 throughout the owned half and 0 in the other half. `sdata` is 0 whenever `sdata_oe` is 0.
- R3: With `fmt_i2s`=0, the MSB is launched on the first `bclk` falling edge at or after the `lrclk` transition into the owned level.
- R4: With `fmt_i2s`=1, the first such falling edge launches a 0 and the MSB follows on the second.
- R5: After the 16th data bit of an owned half, `sdata` stays 0 until that half ends.
- R6: The word sent in a half-frame is the one held when the half began. A sample accepted during the half is sent in the next owned half and does not alter the current one.
- R7: `s_ready` is 1 when the holding register is empty and 0 when it is full. A sample offered while `s_ready`=0 is not taken.
- R8: If no sample is held when an owned half-frame begins, that half carries all zeros with `sdata_oe`=1.
- R9: `clr`=1 empties the holding register and the shift state. Afterwards `s_ready`=1, `sdata`=0 and `sdata_oe`=0 while the other channel's half is on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `bclk` |
| clr | input | 1 | Active-high clear of all state |
| bclk | input | 1 | External bit clock; bits launch on its falling edge |
| lrclk | input | 1 | External left/right half-frame clock |
| chan_right | input | 1 | Strap: 1 = owns `lrclk` high half, 0 = owns low half |
| fmt_i2s | input | 1 | Strap: 1 = one-bit delayed framing, 0 = left-justified |
| s_data | input | 16 | Sample to send, two's complement |
| s_valid | input | 1 | Sample on `s_data` is valid |
| s_ready | output | 1 | Holding register empty, sample can be taken |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the shared data pin |

## Verification
The hardest situation to reach is a new sample arriving while an owned half-frame is partway through its shift. The word on the line must stay intact, and the new sample must wait for the following half. The bench reaches this by raising `s_valid` from inside its half-frame driver at a chosen bit index, after the half has already drawn the held word. It then checks both that half and the next owned half. A second hard case is an owned half that begins with nothing held. The bench creates it by running a half-frame with no push after the previous word has been drawn, and it checks that the pin still drives zeros.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int SAMPLE_W_DEF = 16;

  typedef enum logic {
    FRAME_LJ  = 1'b0,
    FRAME_I2S = 1'b1
  } frame_e;

  function automatic logic owns_half(input logic lr_level, input logic right_sel);
    return lr_level == right_sel;
  endfunction
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = q[b] & ~prev[b];
    assign fall[b] = ~q[b] & prev[b];
  end
endmodule

// File: rtl/sap_hold.sv
module sap_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s_data,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic         take,
  output logic [W-1:0] word
);
  logic         full;
  logic [W-1:0] data;

  assign s_ready = ~full;
  assign word    = full ? data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (s_valid && s_ready) begin
      full <= 1'b1;
      data <= s_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R7
  accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (full && !s_ready));

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> $stable(data));
endmodule

// File: rtl/sap_shift.sv
module sap_shift
  import sap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bclk_fall,
  input  logic         lr_level,
  input  logic         lr_edge,
  input  logic         chan_right,
  input  logic         fmt_i2s,
  input  logic [W-1:0] word_in,
  output logic         take,
  output logic         sdata,
  output logic         sdata_oe
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  logic             own, start, delayed;
  logic [W-1:0]     sh, word_now;
  logic [CNT_W-1:0] cnt, cnt_now;
  logic             skip, skip_now;
  logic             data_r, oe_r;

  assign own     = owns_half(lr_level, chan_right);
  assign start   = lr_edge && own;
  assign take    = start;
  assign delayed = (frame_e'(fmt_i2s) == FRAME_I2S);

  always_comb begin
    cnt_now  = start ? '0 : cnt;
    skip_now = start ? delayed : skip;
    word_now = start ? word_in : sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      skip   <= 1'b0;
      data_r <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      oe_r <= own;
      if (!own) begin
        data_r <= 1'b0;
      end else if (bclk_fall) begin
        skip <= 1'b0;
        if (skip_now) begin
          data_r <= 1'b0;
          sh     <= word_now;
          cnt    <= cnt_now;
        end else if (cnt_now < LAST) begin
          data_r <= word_now[W-1];
          sh     <= {word_now[W-2:0], 1'b0};
          cnt    <= cnt_now + 1'b1;
        end else begin
          data_r <= 1'b0;
          sh     <= word_now;
          cnt    <= cnt_now;
        end
      end else if (start) begin
        sh     <= word_now;
        cnt    <= '0;
        skip   <= delayed;
        data_r <= 1'b0;
      end
    end
  end

  assign sdata    = data_r;
  assign sdata_oe = oe_r;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R1
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (own && !bclk_fall && !start) |=> $stable(data_r));

  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata);

  // R4
  i2s_first_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && delayed && bclk_fall) |=> !data_r);
endmodule

// File: rtl/serial_sample_tx.sv
module serial_sample_tx
  import sap_pkg::*;
#(
  parameter int SAMPLE_W    = SAMPLE_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                chan_right,
  input  logic                fmt_i2s,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_valid,
  output logic                s_ready,
  output logic                sdata,
  output logic                sdata_oe
);
  localparam int BCLK_I = 0;
  localparam int LR_I   = 1;

  logic [1:0]          clk_q, clk_rise, clk_fall;
  logic                take;
  logic [SAMPLE_W-1:0] word;

  sap_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (clr),
    .d    ({lrclk, bclk}),
    .q    (clk_q),
    .rise (clk_rise),
    .fall (clk_fall)
  );

  sap_hold #(.W(SAMPLE_W)) u_hold (
    .clk     (clk),
    .rst     (clr),
    .s_data  (s_data),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .take    (take),
    .word    (word)
  );

  sap_shift #(.W(SAMPLE_W)) u_shift (
    .clk        (clk),
    .rst        (clr),
    .bclk_fall  (clk_fall[BCLK_I]),
    .lr_level   (clk_q[LR_I]),
    .lr_edge    (clk_rise[LR_I] | clk_fall[LR_I]),
    .chan_right (chan_right),
    .fmt_i2s    (fmt_i2s),
    .word_in    (word),
    .take       (take),
    .sdata      (sdata),
    .sdata_oe   (sdata_oe)
  );
endmodule

// File: tb/serial_sample_tx_bench.sv
module serial_sample_tx_bench;
  localparam int W  = 16;
  localparam int HB = 24;
  localparam int BH = 8;
  localparam int NV = 6;
  // vector: {chan_right, fmt_i2s, word}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h8000}, {1'b0, 1'b0, 16'h7FFF}, {1'b1, 1'b1, 16'hA5C3},
    {1'b0, 1'b1, 16'h0001}, {1'b1, 1'b1, 16'hFFFF}, {1'b0, 1'b0, 16'h1234}
  };

  logic clk = 0, clr = 1, bclk = 1, lrclk = 0, chan_right = 0, fmt_i2s = 0;
  logic [W-1:0] s_data = '0;
  logic s_valid = 0, s_ready, sdata, sdata_oe;
  int total = 0, bad = 0;
  logic done = 0;

  always #4 clk = ~clk;

  serial_sample_tx u_serial_sample_tx (
    .clk(clk), .clr(clr), .bclk(bclk), .lrclk(lrclk), .chan_right(chan_right),
    .fmt_i2s(fmt_i2s), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [HB-1:0] exp_bits(input logic [W-1:0] w, input logic i2s);
    return i2s ? {1'b0, w, 7'b0} : {w, 8'b0};
  endfunction

  task automatic do_clear();
    @(negedge clk); clr = 1;
    repeat (3) @(negedge clk);
    clr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] w);
    @(negedge clk); s_valid = 1; s_data = w;
    @(negedge clk); s_valid = 0;
  endtask

  // one half-frame; lrclk moves with the first bclk fall; optional push at bit push_at
  task automatic run_half(input logic lvl, input int push_at, input logic [W-1:0] pw,
                          output logic [HB-1:0] bits, output logic oe_all, output logic oe_any);
    oe_all = 1; oe_any = 0;
    for (int b = 0; b < HB; b++) begin
      @(negedge clk); bclk = 0;
      if (b == 0) lrclk = lvl;
      if (b == push_at) begin s_valid = 1; s_data = pw; end
      repeat (BH) @(negedge clk);
      bits[HB-1-b] = sdata;
      oe_all = oe_all & sdata_oe;
      oe_any = oe_any | sdata_oe;
      s_valid = 0;
      bclk = 1;
      repeat (BH - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [HB-1:0] bits;
    logic oe_all, oe_any;
    logic c, f;
    logic [W-1:0] w;

    // R9: reset state with the other channel's half on the bus
    chan_right = 1; fmt_i2s = 0; lrclk = 0;
    do_clear();
    check("R9 reset sdata_oe", sdata_oe, 0);
    check("R9 reset sdata", sdata, 0);
    check("R9 reset s_ready", s_ready, 1);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      c = VEC[i][17]; f = VEC[i][16]; w = VEC[i][15:0];
      chan_right = c; fmt_i2s = f; lrclk = ~c;
      do_clear();
      push(w);
      check("R7 ready low when full", s_ready, 0);
      run_half(~c, -1, '0, bits, oe_all, oe_any);
      check("R2 other half oe off", oe_any, 0);
      check("R2 other half data zero", bits, 0);
      run_half(c, -1, '0, bits, oe_all, oe_any);
      check("R2 own half oe on", oe_all, 1);
      check(f ? "R4 i2s word R1 R5" : "R3 lj word R1 R5", bits, exp_bits(w, f));
    end

    // R6: mid-frame push does not corrupt current word
    chan_right = 1; fmt_i2s = 0; lrclk = 0;
    do_clear();
    push(16'hC0DE);
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, 4, 16'h5A5A, bits, oe_all, oe_any);
    check("R6 current word kept", bits, exp_bits(16'hC0DE, 0));
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, -1, '0, bits, oe_all, oe_any);
    check("R6 new word next half", bits, exp_bits(16'h5A5A, 0));

    // R8: underrun gives zeros while driving
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, -1, '0, bits, oe_all, oe_any);
    check("R8 underrun zeros", bits, 0);
    check("R8 underrun oe on", oe_all, 1);

    // R7: offer while full is refused
    fmt_i2s = 1;
    push(16'h0F0F);
    check("R7 ready low after accept", s_ready, 0);
    @(negedge clk); s_valid = 1; s_data = 16'hBEEF;
    repeat (3) @(negedge clk);
    s_valid = 0;
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, -1, '0, bits, oe_all, oe_any);
    check("R7 held word sent", bits, exp_bits(16'h0F0F, 1));
    check("R7 ready back high", s_ready, 1);
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, -1, '0, bits, oe_all, oe_any);
    check("R7 refused word not sent", bits, 0);

    // R9: clear empties the holding register
    lrclk = 0;
    push(16'h1111);
    do_clear();
    check("R9 ready after clear", s_ready, 1);
    run_half(0, -1, '0, bits, oe_all, oe_any);
    run_half(1, -1, '0, bits, oe_all, oe_any);
    check("R9 cleared word dropped", bits, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule